// File: doc/BRIEF.md
# Layer Priority Mixer with Shadow/Highlight

This block composites one output pixel per pixel strobe for a tile-based video display processor. It takes a pixel from each of two background planes (B and A), a pixel from the sprite line buffer and the background colour register. It picks the visible colour index, an intensity level and a code naming the layer that won. Each layer pixel is 7 bits wide. Bit 6 is the priority flag, bits 5:4 are the palette and bits 3:0 are the colour.

An optional shadow/highlight mode derives the intensity from the priority flags. In that mode, two reserved sprite indices do not draw. They act as operators on the intensity instead. An optional left-blank mode replaces the first pixels of each line with the background colour. A display-enable flag forces the output index to an all-ones value when it is low.

Results appear one clock after the input pixel. They hold until the next valid pixel.

Top module: `layer_mixer`

## Requirements
- R1: A pixel presented with `pixValid` high produces `outColor`, `outInten` and `outSrc` on the next clock, with `outValid` high. While `pixValid` is low, `outValid` goes low on the next clock and the other outputs keep their values. After reset, `outValid` is 0, `outColor` is 0, `outInten` is 01 and `outSrc` is 0.
- R2: A layer pixel is transparent when bits 3:0 are zero. When all three layers are transparent, the output is `bgColor` with source code 0. The background counts as priority 0.
- R3: Layers are tried in the order plane B, plane A, sprite. A layer replaces the current pixel when it is non-transparent and its bit 6 is greater than or equal to the bit 6 of the current pixel. The source codes are 1 for plane B, 2 for plane A and 3 for sprite.
- R4: The intensity codes are 00 for shadow, 01 for normal and 10 for highlight. In shadow/highlight mode, the base intensity is normal when bit 6 of plane B or bit 6 of plane A is set, whether or not that pixel is transparent. Otherwise the base intensity is shadow.
- R5: In shadow/highlight mode, a winning sprite with index 0x3E is not drawn. It raises the intensity by one step (shadow to normal, normal to highlight, saturating at highlight). The plane pixel and its source code stay.
- R6: In shadow/highlight mode, a winning sprite with index 0x3F is not drawn. It forces shadow, and the plane pixel stays.
- R7: In shadow/highlight mode, a drawn sprite whose bits 3:0 are 0xE forces normal intensity. Any other drawn sprite with bit 6 set lifts shadow to normal, and one with bit 6 clear leaves the base intensity unchanged.
- R8: When `leftBlank` is set, the valid pixel that carries `lineStart` and the next 7 valid pixels output `bgColor` with source code 0. In shadow/highlight mode these pixels also take shadow intensity. Later pixels of the line are mixed normally.
- R9: When `dispEn` is low, `outColor` is 0x3F.
- R10: With shadow/highlight mode off, the same selection applies, sprite indices 0x3E and 0x3F are drawn as ordinary colours, and `outInten` is 01.
- R11: `outInten` never reads 11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rstN | input | 1 | Active-low synchronous reset |
| pixValid | input | 1 | Input pixel strobe |
| lineStart | input | 1 | Marks the first valid pixel of a line |
| planeB | input | 7 | Plane B pixel: {priority, palette[1:0], colour[3:0]} |
| planeA | input | 7 | Plane A (or window) pixel, same format |
| sprite | input | 7 | Sprite line buffer pixel, same format |
| bgColor | input | 6 | Background colour index |
| shMode | input | 1 | Shadow/highlight mode enable |
| leftBlank | input | 1 | Left-column blank enable |
| dispEn | input | 1 | Display output enable |
| outColor | output | 6 | Selected colour index |
| outInten | output | 2 | Intensity: 00 shadow, 01 normal, 10 highlight |
| outSrc | output | 2 | Winning layer: 0 background, 1 B, 2 A, 3 sprite |
| outValid | output | 1 | Output strobe, one cycle after pixValid |

## Verification
The bench targets the equal-priority tie, where a design that used a strict comparison would keep plane B over plane A. It also checks a transparent pixel whose priority bit is set. A design that got that case wrong would either let the pixel block lower layers or drop its contribution to the base intensity. The operator sprites are tried as winners and as losers of the priority test. A wrong design would draw 0x3E or 0x3F in shadow/highlight mode, or apply the operator even though the sprite lost. The left-blank window is probed at its eighth and ninth pixels. An off-by-one counter would blank seven or nine pixels.

// File: rtl/mix_pkg.sv
package mix_pkg;
  localparam int COLOR_W = 6;
  localparam int PIX_W   = COLOR_W + 1;
  localparam int PRI_BIT = PIX_W - 1;

  typedef enum logic [1:0] {
    INT_SHADOW = 2'b00,
    INT_NORMAL = 2'b01,
    INT_HIGH   = 2'b10
  } inten_t;

  typedef enum logic [1:0] {
    SRC_BG  = 2'd0,
    SRC_B   = 2'd1,
    SRC_A   = 2'd2,
    SRC_SPR = 2'd3
  } src_t;

  typedef struct packed {
    logic capture;
    logic blankLeft;
  } mix_ctl_t;

  function automatic inten_t raiseInten(input inten_t cur);
    case (cur)
      INT_SHADOW: raiseInten = INT_NORMAL;
      default:    raiseInten = INT_HIGH;
    endcase
  endfunction
endpackage

// File: rtl/mix_ctrl.sv
module mix_ctrl #(
  parameter int BLANK_PIXELS = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic pixValid,
  input  logic lineStart,
  input  logic leftBlank,
  output mix_pkg::mix_ctl_t ctl
);
  localparam int CNT_W = $clog2(BLANK_PIXELS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(BLANK_PIXELS);

  logic [CNT_W-1:0] pixCnt;
  logic inLeft;

  assign inLeft = lineStart || (pixCnt < CNT_MAX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pixCnt <= CNT_MAX;
    end else if (pixValid) begin
      if (lineStart)
        pixCnt <= CNT_W'(1);
      else if (pixCnt != CNT_MAX)
        pixCnt <= pixCnt + CNT_W'(1);
    end
  end

  always_comb begin
    ctl.capture   = pixValid;
    ctl.blankLeft = leftBlank && inLeft;
  end
endmodule

// File: rtl/mix_datapath.sv
module mix_datapath
  import mix_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  mix_ctl_t           ctl,
  input  logic [PIX_W-1:0]   planeB,
  input  logic [PIX_W-1:0]   planeA,
  input  logic [PIX_W-1:0]   sprite,
  input  logic [COLOR_W-1:0] bgColor,
  input  logic               shMode,
  input  logic               dispEn,
  output logic [COLOR_W-1:0] outColor,
  output logic [1:0]         outInten,
  output logic [1:0]         outSrc,
  output logic               outValid
);
  localparam logic [COLOR_W-1:0] OP_RAISE = 6'h3E;
  localparam logic [COLOR_W-1:0] OP_SHADE = 6'h3F;
  localparam logic [COLOR_W-1:0] BLANKED  = 6'h3F;

  logic [COLOR_W-1:0] curColor;
  logic               curPri;
  src_t               curSrc;
  inten_t             inten;
  inten_t             baseInten;
  logic               bOpaque, aOpaque, sOpaque, sprWins;

  assign bOpaque = |planeB[3:0];
  assign aOpaque = |planeA[3:0];
  assign sOpaque = |sprite[3:0];

  always_comb begin
    curColor  = bgColor;
    curPri    = 1'b0;
    curSrc    = SRC_BG;
    sprWins   = 1'b0;
    baseInten = (planeB[PRI_BIT] || planeA[PRI_BIT]) ? INT_NORMAL : INT_SHADOW;
    inten     = INT_NORMAL;
    if (ctl.blankLeft) begin
      inten = shMode ? INT_SHADOW : INT_NORMAL;
    end else begin
      if (bOpaque) begin
        curColor = planeB[COLOR_W-1:0];
        curPri   = planeB[PRI_BIT];
        curSrc   = SRC_B;
      end
      if (aOpaque && (planeA[PRI_BIT] >= curPri)) begin
        curColor = planeA[COLOR_W-1:0];
        curPri   = planeA[PRI_BIT];
        curSrc   = SRC_A;
      end
      sprWins = sOpaque && (sprite[PRI_BIT] >= curPri);
      if (shMode) begin
        inten = baseInten;
        if (sprWins) begin
          if (sprite[COLOR_W-1:0] == OP_RAISE) begin
            inten = raiseInten(baseInten);
          end else if (sprite[COLOR_W-1:0] == OP_SHADE) begin
            inten = INT_SHADOW;
          end else begin
            curColor = sprite[COLOR_W-1:0];
            curSrc   = SRC_SPR;
            if (sprite[3:0] == 4'hE)
              inten = INT_NORMAL;
            else if (sprite[PRI_BIT])
              inten = INT_NORMAL;
          end
        end
      end else if (sprWins) begin
        curColor = sprite[COLOR_W-1:0];
        curSrc   = SRC_SPR;
      end
    end
    if (!dispEn)
      curColor = BLANKED;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outColor <= '0;
      outInten <= INT_NORMAL;
      outSrc   <= SRC_BG;
      outValid <= 1'b0;
    end else begin
      outValid <= ctl.capture;
      if (ctl.capture) begin
        outColor <= curColor;
        outInten <= inten;
        outSrc   <= curSrc;
      end
    end
  end
endmodule

// File: rtl/layer_mixer.sv
module layer_mixer #(
  parameter int BLANK_PIXELS = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       pixValid,
  input  logic       lineStart,
  input  logic [6:0] planeB,
  input  logic [6:0] planeA,
  input  logic [6:0] sprite,
  input  logic [5:0] bgColor,
  input  logic       shMode,
  input  logic       leftBlank,
  input  logic       dispEn,
  output logic [5:0] outColor,
  output logic [1:0] outInten,
  output logic [1:0] outSrc,
  output logic       outValid
);
  mix_pkg::mix_ctl_t ctl;

  mix_ctrl #(.BLANK_PIXELS(BLANK_PIXELS)) ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid),
    .lineStart(lineStart), .leftBlank(leftBlank), .ctl(ctl)
  );

  mix_datapath dp (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .planeB(planeB), .planeA(planeA), .sprite(sprite),
    .bgColor(bgColor), .shMode(shMode), .dispEn(dispEn),
    .outColor(outColor), .outInten(outInten), .outSrc(outSrc),
    .outValid(outValid)
  );
endmodule

// File: rtl/mix_checker.sv
module mix_checker (
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic [6:0] planeB,
  input logic [6:0] planeA,
  input logic [6:0] sprite,
  input logic [5:0] bgColor,
  input logic       shMode,
  input logic       dispEn,
  input logic [5:0] outColor,
  input logic [1:0] outInten,
  input logic [1:0] outSrc,
  input logic       outValid
);
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rstN)
    pixValid |=> outValid); // R1
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    !pixValid |=> !outValid && $stable(outColor) && $stable(outInten) && $stable(outSrc)); // R1
  AST_ALL_CLEAR_BG: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && dispEn && planeB[3:0] == 4'h0 && planeA[3:0] == 4'h0 && sprite[3:0] == 4'h0)
    |=> (outColor == $past(bgColor)) && (outSrc == 2'd0)); // R2
  AST_DISABLED_COLOR: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !dispEn) |=> outColor == 6'h3F); // R9
  AST_NOSH_NORMAL: assert property (@(posedge clk) disable iff (!rstN)
    (pixValid && !shMode) |=> outInten == 2'b01); // R10
  AST_INTEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outInten != 2'b11); // R11
endmodule

bind layer_mixer mix_checker chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid),
  .planeB(planeB), .planeA(planeA), .sprite(sprite),
  .bgColor(bgColor), .shMode(shMode), .dispEn(dispEn),
  .outColor(outColor), .outInten(outInten), .outSrc(outSrc),
  .outValid(outValid)
);

// File: tb/layer_mixer_test.sv
`timescale 1ns/1ps
module layer_mixer_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic pixValid = 1'b0, lineStart = 1'b0;
  logic [6:0] planeB = '0, planeA = '0, sprite = '0;
  logic [5:0] bgColor = 6'h15;
  logic shMode = 1'b0, leftBlank = 1'b0, dispEn = 1'b1;
  logic [5:0] outColor;
  logic [1:0] outInten, outSrc;
  logic outValid;

  int checks = 0;
  int errors = 0;

  localparam logic [1:0] SH = 2'b00, NO = 2'b01, HI = 2'b10;

  layer_mixer uut (
    .clk(clk), .rstN(rstN), .pixValid(pixValid), .lineStart(lineStart),
    .planeB(planeB), .planeA(planeA), .sprite(sprite), .bgColor(bgColor),
    .shMode(shMode), .leftBlank(leftBlank), .dispEn(dispEn),
    .outColor(outColor), .outInten(outInten), .outSrc(outSrc),
    .outValid(outValid)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [5:0] eCol,
                       input logic [1:0] eInt, input logic [1:0] eSrc);
    checks++;
    if (outValid !== 1'b1 || outColor !== eCol || outInten !== eInt || outSrc !== eSrc) begin
      errors++;
      $display("FAIL %s: got valid=%b col=%h int=%b src=%0d, expected valid=1 col=%h int=%b src=%0d",
               tag, outValid, outColor, outInten, outSrc, eCol, eInt, eSrc);
    end
  endtask

  // Presents one pixel; returns one cycle later with the result registered.
  task automatic send(input logic [6:0] b, input logic [6:0] a, input logic [6:0] s,
                      input logic ls);
    planeB = b; planeA = a; sprite = s; lineStart = ls; pixValid = 1'b1;
    @(posedge clk); #1;
    pixValid = 1'b0; lineStart = 1'b0;
  endtask

  task automatic t_reset();
    checks++;
    if (outValid !== 1'b0 || outColor !== 6'h00 || outInten !== NO || outSrc !== 2'd0) begin
      errors++;
      $display("FAIL R1 reset: got valid=%b col=%h int=%b src=%0d, expected 0/00/01/0",
               outValid, outColor, outInten, outSrc);
    end
  endtask

  task automatic t_transparent();
    shMode = 0;
    send(7'h00, 7'h00, 7'h00, 0); check("R2 all clear", 6'h15, NO, 2'd0);
    send(7'h40, 7'h70, 7'h60, 0); check("R2 clear with priority bits", 6'h15, NO, 2'd0);
  endtask

  task automatic t_priority();
    shMode = 0;
    send(7'h12, 7'h23, 7'h00, 0); check("R3 A ties B", 6'h23, NO, 2'd2);
    send(7'h52, 7'h23, 7'h00, 0); check("R3 B high beats A low", 6'h12, NO, 2'd1);
    send(7'h12, 7'h23, 7'h31, 0); check("R3 sprite ties A", 6'h31, NO, 2'd3);
    send(7'h52, 7'h00, 7'h31, 0); check("R3 sprite low loses to B high", 6'h12, NO, 2'd1);
    send(7'h12, 7'h60, 7'h31, 0); check("R3 clear A does not block", 6'h31, NO, 2'd3);
  endtask

  task automatic t_shadow_base();
    shMode = 1;
    send(7'h12, 7'h23, 7'h00, 0); check("R4 both low shadow", 6'h23, SH, 2'd2);
    send(7'h52, 7'h23, 7'h00, 0); check("R4 B high normal", 6'h12, NO, 2'd1);
    send(7'h40, 7'h05, 7'h00, 0); check("R4 clear B priority counts", 6'h05, NO, 2'd2);
  endtask

  task automatic t_raise();
    shMode = 1;
    send(7'h52, 7'h00, 7'h7E, 0); check("R5 raise to highlight", 6'h12, HI, 2'd1);
    send(7'h12, 7'h00, 7'h3E, 0); check("R5 raise shadow to normal", 6'h12, NO, 2'd1);
    send(7'h52, 7'h00, 7'h3E, 0); check("R5 losing operator ignored", 6'h12, NO, 2'd1);
    checks++;
    if (outInten === 2'b11) begin
      errors++; $display("FAIL R11: got int=11, expected not 11");
    end
  endtask

  task automatic t_shade();
    shMode = 1;
    send(7'h52, 7'h00, 7'h7F, 0); check("R6 force shadow", 6'h12, SH, 2'd1);
  endtask

  task automatic t_drawn_sprite();
    shMode = 1;
    send(7'h12, 7'h23, 7'h0E, 0); check("R7 colour E normal", 6'h0E, NO, 2'd3);
    send(7'h12, 7'h23, 7'h05, 0); check("R7 low sprite keeps shadow", 6'h05, SH, 2'd3);
    send(7'h12, 7'h23, 7'h45, 0); check("R7 high sprite lifts", 6'h05, NO, 2'd3);
  endtask

  task automatic t_left_blank();
    shMode = 1; leftBlank = 1;
    for (int i = 0; i < 8; i++) begin
      send(7'h52, 7'h00, 7'h00, i == 0);
      check($sformatf("R8 blanked pixel %0d", i), 6'h15, SH, 2'd0);
      @(posedge clk); #1; // idle gap must not advance the count
    end
    send(7'h52, 7'h00, 7'h00, 0); check("R8 ninth pixel mixed", 6'h12, NO, 2'd1);
    shMode = 0;
    send(7'h52, 7'h00, 7'h00, 1); check("R8 blank without shadow mode", 6'h15, NO, 2'd0);
    leftBlank = 0;
    send(7'h52, 7'h00, 7'h00, 1); check("R8 disabled no blank", 6'h12, NO, 2'd1);
  endtask

  task automatic t_disable();
    shMode = 0; dispEn = 0;
    send(7'h52, 7'h00, 7'h00, 0); check("R9 display off", 6'h3F, NO, 2'd1);
    dispEn = 1;
  endtask

  task automatic t_no_sh();
    shMode = 0;
    send(7'h12, 7'h00, 7'h3E, 0); check("R10 3E drawn", 6'h3E, NO, 2'd3);
    send(7'h12, 7'h00, 7'h7F, 0); check("R10 3F drawn", 6'h3F, NO, 2'd3);
  endtask

  task automatic t_hold();
    shMode = 0;
    send(7'h12, 7'h00, 7'h00, 0);
    planeB = 7'h25; planeA = 7'h33; sprite = 7'h41;
    @(posedge clk); #1;
    checks++;
    if (outValid !== 1'b0 || outColor !== 6'h12 || outSrc !== 2'd1) begin
      errors++;
      $display("FAIL R1 hold: got valid=%b col=%h src=%0d, expected valid=0 col=12 src=1",
               outValid, outColor, outSrc);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 t_reset();
    rstN = 1'b1;
    @(posedge clk); #1;
    t_transparent();
    t_priority();
    t_shadow_base();
    t_raise();
    t_shade();
    t_drawn_sprite();
    t_left_blank();
    t_disable();
    t_no_sh();
    t_hold();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    checks++; errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule